// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block gathers up to fifteen interrupt request lines, numbered 1 to 15, into a pending register. A rising edge on a line, or a software write, marks that line pending. An enable register gates the pending lines. The block drives the processor with a 4-bit level: the number of the highest-numbered line that is both pending and enabled. The line number is its priority, so line 15 outranks line 1. Line number 0 does not exist, and level 0 means that no interrupt is requested.

Software reaches the block through a simple word-wide register port with write strobe, address and data, and a combinational read. There are four word registers. Two of them are write-one-to-act strobes: one sets pending bits and one clears them. When the processor takes an interrupt, it returns the level it is servicing on the acknowledge port, and that line's pending bit is cleared.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the enable register reads 0, the pending register reads 0, and `irq_level` is 0.
- R2: A write to offset 0x0 loads the enable register, and a read of offset 0x0 returns it. Bit n set to 1 enables line n and bit n set to 0 blocks it. Bits 16 to 31 read 0.
- R3: A write to offset 0x8 sets pending bit n for every data bit n written as 1, in the clock edge of the write. Bits written as 0 leave the pending register unchanged. A read of offset 0x4 returns the pending register.
- R4: A write to offset 0xC clears pending bit n for every data bit n written as 1. Bits written as 0 leave the pending register unchanged.
- R5: A 0-to-1 transition of `src_in[n]` between two clock edges sets pending bit n at the second edge. A line that stays high does not set its bit again after the bit is cleared.
- R6: If a set (rising edge or force write) and a clear (clear write or acknowledge) hit the same bit at the same edge, the bit ends up set.
- R7: `irq_level` equals the highest n for which the pending bit and the enable bit are both 1, and equals 0 when there is no such n.
- R8: With `ack_valid` high and `ack_level` equal to L (1 to 15), pending bit L is cleared at the next clock edge. `ack_level` 0 changes nothing.
- R9: Bit 0 of the enable and pending registers always reads 0. Writes to bit 0 and activity on `src_in[0]` have no effect on these bits.
- R10: Reads of offsets 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| src_in | input | 16 | Request lines; bit n is line n, bit 0 unused |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_level | input | 4 | Level being serviced |
| irq_level | output | 4 | Highest enabled pending line, 0 for none |

## Verification
The hardest situation to reach from the ports is a set and a clear landing on the same pending bit at the same edge. This needs a line to rise in exactly the cycle of a clear write or an acknowledge aimed at that line. The stimulus drives each cycle's inputs explicitly. It lowers a line in one cycle, then raises it in the same cycle that carries the clear write or the acknowledge. It also pairs a force write with an acknowledge of the same level. A behavioural model tracks the line history and checks the outcome on every clock.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Register byte offsets
    localparam int OFS_ENABLE = 'h0;
    localparam int OFS_PEND   = 'h4;
    localparam int OFS_SET    = 'h8;
    localparam int OFS_CLR    = 'hC;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_ENABLE,
        RSEL_PEND,
        RSEL_SET,
        RSEL_CLR
    } rsel_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] rise
);
    logic [NUM_LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lines;
        rise   = lines & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output rsel_e                rsel,
    output logic                 enable_we,
    output logic [NUM_LINES-1:0] set_bits,
    output logic [NUM_LINES-1:0] clr_bits
);
    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_ENABLE): rsel = RSEL_ENABLE;
            ADDR_W'(OFS_PEND):   rsel = RSEL_PEND;
            ADDR_W'(OFS_SET):    rsel = RSEL_SET;
            ADDR_W'(OFS_CLR):    rsel = RSEL_CLR;
            default:             rsel = RSEL_NONE;
        endcase
        enable_we = we && (rsel == RSEL_ENABLE);
        set_bits  = (we && rsel == RSEL_SET) ? wdata : '0;
        clr_bits  = (we && rsel == RSEL_CLR) ? wdata : '0;
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_LINES = 16,
    parameter int LVL_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] vec,
    output logic [LVL_W-1:0]     level
);
    always_comb begin
        level = '0;
        for (int i = 1; i < NUM_LINES; i++) begin
            if (vec[i]) level = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int LVL_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic [NUM_LINES-1:0] src_in,
    input  logic                 ack_valid,
    input  logic [LVL_W-1:0]     ack_level,
    output logic [LVL_W-1:0]     irq_level
);
    localparam logic [NUM_LINES-1:0] LIVE = ~NUM_LINES'(1);

    typedef struct packed {
        logic [NUM_LINES-1:0] enable;
        logic [NUM_LINES-1:0] pend;
    } state_t;

    state_t st_d, st_q;

    rsel_e                rsel;
    logic                 enable_we;
    logic [NUM_LINES-1:0] wr_set, wr_clr, rise, ack_bits;
    logic [NUM_LINES-1:0] set_all, clr_all;
    logic [NUM_LINES-1:0] cur_enable, cur_pend;
    logic                 unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:NUM_LINES];

    irq_edge_detect #(.NUM_LINES(NUM_LINES)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (src_in),
        .rise  (rise)
    );

    irq_reg_decode #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) dec_i (
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata[NUM_LINES-1:0]),
        .rsel      (rsel),
        .enable_we (enable_we),
        .set_bits  (wr_set),
        .clr_bits  (wr_clr)
    );

    irq_prio_enc #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) enc_i (
        .vec   (cur_pend & cur_enable),
        .level (irq_level)
    );

    always_comb begin
        ack_bits = '0;
        if (ack_valid) ack_bits[ack_level] = 1'b1;
        set_all = (wr_set | rise) & LIVE;
        clr_all = wr_clr | ack_bits;

        st_d = st_q;
        if (enable_we) st_d.enable = reg_wdata[NUM_LINES-1:0] & LIVE;
        st_d.pend = ((st_q.pend & ~clr_all) | set_all) & LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_enable = st_q.enable;
    assign cur_pend   = st_q.pend;

    always_comb begin
        reg_rdata = '0;
        unique case (rsel)
            RSEL_ENABLE: reg_rdata[NUM_LINES-1:0] = st_q.enable;
            RSEL_PEND:   reg_rdata[NUM_LINES-1:0] = st_q.pend;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_LINES = 16,
    parameter int LVL_W     = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_we,
    input logic [3:0]           reg_addr,
    input logic [NUM_LINES-1:0] wdata_lo,
    input logic                 ack_valid,
    input logic [LVL_W-1:0]     ack_level,
    input logic [LVL_W-1:0]     irq_level,
    input logic [NUM_LINES-1:0] cur_enable,
    input logic [NUM_LINES-1:0] cur_pend,
    input logic [NUM_LINES-1:0] set_all
);
    localparam logic [NUM_LINES-1:0] LIVE = ~NUM_LINES'(1);

    // R3: a set write leaves every written-one bit pending
    a_r3_set_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'h8) |=>
        ((cur_pend & $past(wdata_lo) & LIVE) == ($past(wdata_lo) & LIVE)));

    // R4: a clear write removes bits that were not also being set
    a_r4_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 4'hC) |=>
        ((cur_pend & $past(wdata_lo) & ~$past(set_all) & LIVE) == '0));

    // R6: every bit being set is pending afterwards, whatever clears collide
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((cur_pend & $past(set_all)) == $past(set_all)));

    // R7: the level names an enabled pending line and nothing higher is active
    a_r7_level_top: assert property (@(posedge clk) disable iff (!rst_n)
        (((cur_pend & cur_enable) >> irq_level) <= 1) &&
        ((irq_level == '0) || (cur_pend[irq_level] && cur_enable[irq_level])));

    // R8: an acknowledge clears its line unless a set collides
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_level != '0) |=>
        (cur_pend[$past(ack_level)] == $past(set_all[ack_level])));

    // R9: bit 0 never holds state
    a_r9_bit0_dead: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_pend[0] && !cur_enable[0]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (4'(reg_addr)),
    .wdata_lo   (reg_wdata[NUM_LINES-1:0]),
    .ack_valid  (ack_valid),
    .ack_level  (ack_level),
    .irq_level  (irq_level),
    .cur_enable (cur_enable),
    .cur_pend   (cur_pend),
    .set_all    (set_all)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] src_in = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_level = '0;
    logic [3:0]  irq_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    int m_enable = 0;
    int m_pend   = 0;
    int m_prev   = 0;
    logic [15:0] src_v = '0;

    always #4 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_in(src_in),
        .ack_valid(ack_valid), .ack_level(ack_level), .irq_level(irq_level)
    );

    function automatic int exp_level();
        int act = m_pend & m_enable;
        int lv = 0;
        for (int i = 1; i < 16; i++) if (act[i]) lv = i;
        return lv;
    endfunction

    function automatic int exp_rdata(input int a);
        if (a == 0) return m_enable;
        if (a == 4) return m_pend;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] wd,
                        input logic av, input logic [3:0] al, input string tag);
        int setb, clrb;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = wd;
        src_in = src_v; ack_valid = av; ack_level = al;
        #1;
        chk(tag, int'(irq_level), exp_level(), "irq_level");
        chk(tag, int'(reg_rdata), exp_rdata(int'(a)), "reg_rdata");
        @(posedge clk);
        setb = (int'(src_v) & ~m_prev) | ((we && a == 4'h8) ? int'(wd[15:0]) : 0);
        clrb = ((we && a == 4'hC) ? int'(wd[15:0]) : 0) | (av ? (1 << al) : 0);
        m_pend = ((m_pend & ~clrb) | setb) & 'hFFFE;
        if (we && a == 4'h0) m_enable = int'(wd[15:0]) & 'hFFFE;
        m_prev = int'(src_v);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 4'd0, tag);
    endtask
    task automatic rd(input logic [3:0] a, input string tag);
        step(1'b0, a, 32'd0, 1'b0, 4'd0, tag);
    endtask
    task automatic ack(input logic [3:0] l, input string tag);
        step(1'b0, 4'h4, 32'd0, 1'b1, l, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset values
        rd(4'h0, "R1"); rd(4'h4, "R1");
        // R2: enable write and readback, upper bits and bit 0 dropped
        wr(4'h0, 32'hFFFF_FFFF, "R2"); rd(4'h0, "R2");
        wr(4'h0, 32'h0000_A5A4, "R2"); rd(4'h0, "R2");
        wr(4'h0, 32'h0000_FFFE, "R2");
        // R3: set write, zero bits inert
        wr(4'h8, 32'h0000_0120, "R3"); rd(4'h4, "R3");
        wr(4'h8, 32'h0, "R3"); rd(4'h4, "R3");
        // R7: blocking by enable
        wr(4'h0, 32'h0000_0020, "R7"); rd(4'h4, "R7");
        wr(4'h0, 32'h0, "R7"); rd(4'h4, "R7");
        wr(4'h0, 32'h0000_FFFE, "R7"); rd(4'h4, "R7");
        // R4: clear write, zero bits inert
        wr(4'hC, 32'h0000_0100, "R4"); rd(4'h4, "R4");
        wr(4'hC, 32'h0, "R4"); rd(4'h4, "R4");
        // R8: acknowledge clears; level 0 ignored
        ack(4'd0, "R8"); rd(4'h4, "R8");
        ack(4'd5, "R8"); rd(4'h4, "R8");
        // R7: priority ordering
        wr(4'h8, 32'h0000_8006, "R7"); rd(4'h4, "R7");
        ack(4'd15, "R7"); rd(4'h4, "R7");
        ack(4'd2, "R7"); ack(4'd1, "R7"); rd(4'h4, "R7");
        // R5: edge sets, steady high does not re-set
        src_v = 16'h1000; rd(4'h4, "R5"); rd(4'h4, "R5");
        wr(4'hC, 32'h0000_1000, "R5"); rd(4'h4, "R5"); rd(4'h4, "R5");
        src_v = 16'h0000; rd(4'h4, "R5");
        src_v = 16'h1000; rd(4'h4, "R5"); rd(4'h4, "R5");
        // R6: rising line collides with clear write and with acknowledge
        src_v = 16'h0000; wr(4'hC, 32'h0000_1000, "R6");
        src_v = 16'h0008; wr(4'hC, 32'h0000_0008, "R6"); rd(4'h4, "R6");
        src_v = 16'h0000; ack(4'd3, "R6"); rd(4'h4, "R6");
        src_v = 16'h0008; ack(4'd3, "R6"); rd(4'h4, "R6");
        // R6: set write collides with acknowledge of same level
        step(1'b1, 4'h8, 32'h0000_0200, 1'b1, 4'd9, "R6"); rd(4'h4, "R6");
        // R9: bit 0 inert
        src_v = 16'h0001; wr(4'h8, 32'h0000_0001, "R9"); rd(4'h4, "R9");
        wr(4'h0, 32'h0000_0001, "R9"); rd(4'h0, "R9"); rd(4'h4, "R9");
        src_v = 16'h0000;
        // R10: strobe registers read zero
        wr(4'h0, 32'h0000_FFFE, "R10");
        rd(4'h8, "R10"); rd(4'hC, "R10"); rd(4'h4, "R10");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule